// File: doc/BRIEF.md
# Auto-Stepping Local Memory Window

This block gives a CPU byte-wide access to a local RAM through a small register window with two independent access ports. Each port holds a 16-bit address pointer and a signed 8-bit step. Software loads the pointer through separate low and high byte registers and picks a step. Each access to the port's data register then moves one byte between the CPU and the RAM at the pointer. After the access the pointer advances by the step. A step of 1 walks the RAM in order, a step of 4 touches every fourth byte, and a negative step walks backwards.

CPUs that do read-modify-write cycles issue a dummy read of the target before they write it. A dummy read of a data register would move the pointer. For this reason data reads are gated by a read-enable bit in a control register that both ports share. While the bit is clear, a data read returns 0xFF and leaves the pointer and the RAM alone. Data writes always go through. The RAM is a plain array inside the block. Both ports address the same memory, and only one bus access is made per cycle.

Top module: `lmp_window`

## Requirements
- R1: Register map: cpu_addr[3:2] selects a slot (0 = control, 1 = port 0, 2 = port 1, 3 = unused). Within a port slot, cpu_addr[1:0] selects 0 = pointer low byte, 1 = pointer high byte, 2 = step, 3 = data. The control register sits at address 0, and its bit 0 is the read enable. Pointer bytes, steps and the control register read back their values. Control bits 7:1 and every unused address read 0.
- R2: After reset, the read enable is clear, both pointers are 0x0000 and both steps are 0x01.
- R3: A write to a port's data register stores the byte at that port's pointer. The pointer then advances by the step.
- R4: With the read enable set, a read of a port's data register returns the byte at the pointer on cpu_rdata. The pointer then advances by the step. All read results appear on cpu_rdata in the cycle after the request and hold until the next read request.
- R5: With the read enable clear, a read of a data register returns 0xFF. It does not move the pointer and does not change the memory.
- R6: The step is two's complement: 0xFF moves the pointer back by one and 0x04 moves it forward by four.
- R7: The pointer wraps modulo 2^16. The byte used is at pointer modulo the RAM size (2^MEM_AW, 1024 by default).
- R8: A write to either pointer byte takes effect at once, and the next data access uses the new address.
- R9: The ports keep separate pointer and step state, and an access through one port never changes the other port's state. Both ports reach the same memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Bus access strobe, one access per cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Register address (REG_AW) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after a read request |

## Verification
The hardest situation is a dummy read hitting a data register just before a real write, while reads are disabled. It must leave no trace, and a missed gate is only visible later as a shifted address. The stimulus sets up that exact pair and then re-reads the written location through a restored pointer. Pointer wrap through 0xFFFF with a negative step, and aliasing above the RAM size, are driven in directed sequences. A long random mix then toggles the read enable, rewrites pointers and steps, and hops between ports. Every read is checked against a bench model of the map.

// File: rtl/lmp_pkg.sv
package lmp_pkg;

  // field offsets inside a port slot (cpu_addr[1:0])
  typedef enum logic [1:0] {
    FLD_PTR_LO = 2'd0,
    FLD_PTR_HI = 2'd1,
    FLD_STEP   = 2'd2,
    FLD_DATA   = 2'd3
  } fld_e;

  localparam int unsigned CTRL_RD_EN_BIT = 0;
  localparam logic [7:0]  RD_BLOCKED_VAL = 8'hFF;

  // per-port register update command from the decoder
  typedef struct packed {
    logic lo_we;
    logic hi_we;
    logic step_we;
    logic xfer;
  } port_cmd_t;

endpackage

// File: rtl/lmp_rst_sync.sv
module lmp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/lmp_decode.sv
module lmp_decode import lmp_pkg::*; #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned REG_AW = 4,
  parameter int unsigned PSEL_W = 1
) (
  input  logic                   req,
  input  logic                   wr,
  input  logic [REG_AW-1:0]      addr,
  input  logic                   rd_en,
  output port_cmd_t [NPORTS-1:0] cmd,
  output logic                   ctrl_hit,
  output logic                   ctrl_we,
  output logic                   port_hit,
  output logic [PSEL_W-1:0]      psel,
  output logic [1:0]             fld,
  output logic                   mem_we,
  output logic                   mem_re,
  output logic                   rd_blocked
);

  localparam int unsigned SLOT_W = REG_AW - 2;

  logic [SLOT_W-1:0] slot;

  assign slot = addr[REG_AW-1:2];
  assign fld  = addr[1:0];

  assign ctrl_hit = (slot == '0) && (fld == 2'd0);
  assign ctrl_we  = req && wr && ctrl_hit;

  always_comb begin
    cmd        = '0;
    port_hit   = 1'b0;
    psel       = '0;
    mem_we     = 1'b0;
    mem_re     = 1'b0;
    rd_blocked = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      if (slot == SLOT_W'(p + 1)) begin
        port_hit = 1'b1;
        psel     = PSEL_W'(p);
        if (req) begin
          case (fld_e'(fld))
            FLD_PTR_LO: cmd[p].lo_we   = wr;
            FLD_PTR_HI: cmd[p].hi_we   = wr;
            FLD_STEP:   cmd[p].step_we = wr;
            FLD_DATA: begin
              if (wr) begin
                mem_we      = 1'b1;
                cmd[p].xfer = 1'b1;
              end else if (rd_en) begin
                mem_re      = 1'b1;
                cmd[p].xfer = 1'b1;
              end else begin
                rd_blocked  = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/lmp_port.sv
module lmp_port import lmp_pkg::*; #(
  parameter int unsigned      PTR_W    = 16,
  parameter int unsigned      STEP_W   = 8,
  parameter logic [STEP_W-1:0] STEP_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_cmd_t         cmd,
  input  logic [7:0]        wdata,
  output logic [PTR_W-1:0]  ptr,
  output logic [STEP_W-1:0] step
);

  // the high pointer byte takes at most one data byte
  localparam int unsigned HI_W = PTR_W - 8;

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [PTR_W-1:0]  step_ext;
  logic              upd_en;

  assign step_ext = PTR_W'($signed(step_q));
  assign upd_en   = cmd.lo_we | cmd.hi_we | cmd.step_we | cmd.xfer;

  always_comb begin
    ptr_d  = ptr_q;
    step_d = step_q;
    if (cmd.lo_we)   ptr_d[7:0]       = wdata;
    if (cmd.hi_we)   ptr_d[PTR_W-1:8] = wdata[HI_W-1:0];
    if (cmd.step_we) step_d           = wdata[STEP_W-1:0];
    if (cmd.xfer)    ptr_d            = ptr_q + step_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= STEP_RST;
    end else if (upd_en) begin
      ptr_q  <= ptr_d;
      step_q <= step_d;
    end
  end

  assign ptr  = ptr_q;
  assign step = step_q;

endmodule

// File: rtl/lmp_ram.sv
module lmp_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rd_q      <= mem[addr];
  end

  assign rdata = rd_q;

  AST_RAM_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re)); // R4

endmodule

// File: rtl/lmp_window.sv
module lmp_window import lmp_pkg::*; #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned STEP_W = 8,
  localparam int unsigned REG_AW = $clog2(NPORTS + 1) + 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata
);

  localparam int unsigned PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic rst_n;

  lmp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  // ---------------- decode ----------------
  port_cmd_t [NPORTS-1:0] cmd;
  logic              ctrl_hit, ctrl_we, port_hit;
  logic [PSEL_W-1:0] psel;
  logic [1:0]        fld;
  logic              mem_we, mem_re, rd_blocked;
  logic              rd_en_q, rd_en_d;

  lmp_decode #(
    .NPORTS (NPORTS),
    .REG_AW (REG_AW),
    .PSEL_W (PSEL_W)
  ) u_dec (
    .req        (cpu_req),
    .wr         (cpu_wr),
    .addr       (cpu_addr),
    .rd_en      (rd_en_q),
    .cmd        (cmd),
    .ctrl_hit   (ctrl_hit),
    .ctrl_we    (ctrl_we),
    .port_hit   (port_hit),
    .psel       (psel),
    .fld        (fld),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .rd_blocked (rd_blocked)
  );

  // ---------------- control register ----------------
  assign rd_en_d = ctrl_we ? cpu_wdata[CTRL_RD_EN_BIT] : rd_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
    end else if (ctrl_we) begin
      rd_en_q <= rd_en_d;
    end
  end

  // ---------------- ports ----------------
  logic [NPORTS-1:0][PTR_W-1:0]  ptr_arr;
  logic [NPORTS-1:0][STEP_W-1:0] step_arr;
  logic [NPORTS-1:0]             xfer_vec;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    lmp_port #(
      .PTR_W  (PTR_W),
      .STEP_W (STEP_W)
    ) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd[g]),
      .wdata (cpu_wdata),
      .ptr   (ptr_arr[g]),
      .step  (step_arr[g])
    );

    assign xfer_vec[g] = cmd[g].xfer;

    AST_DATA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_wr && port_hit && (psel == PSEL_W'(g)) && (fld == FLD_DATA)
      |=> ptr_arr[g] == $past(ptr_arr[g]) + PTR_W'($signed($past(step_arr[g])))); // R3

    AST_BLOCKED_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_wr && !rd_en_q && port_hit && (psel == PSEL_W'(g)) && (fld == FLD_DATA)
      |=> $stable(ptr_arr[g])); // R5

    AST_OTHER_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !(port_hit && (psel == PSEL_W'(g)))
      |=> $stable(ptr_arr[g]) && $stable(step_arr[g])); // R9
  end

  // ---------------- memory ----------------
  logic [PTR_W-1:0]  sel_ptr;
  logic [STEP_W-1:0] sel_step;
  logic [7:0]        ram_rd;

  assign sel_ptr  = ptr_arr[psel];
  assign sel_step = step_arr[psel];

  lmp_ram #(
    .AW (MEM_AW),
    .DW (8)
  ) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (sel_ptr[MEM_AW-1:0]),
    .wdata (cpu_wdata),
    .rdata (ram_rd)
  );

  // ---------------- read path ----------------
  logic       rd_evt;
  logic [7:0] rb_d, rb_q;
  logic       src_mem_q;

  assign rd_evt = cpu_req && !cpu_wr;

  always_comb begin
    rb_d = 8'h00;
    if (ctrl_hit) begin
      rb_d = 8'(rd_en_q) << CTRL_RD_EN_BIT;
    end else if (port_hit) begin
      case (fld_e'(fld))
        FLD_PTR_LO: rb_d = sel_ptr[7:0];
        FLD_PTR_HI: rb_d = 8'(sel_ptr[PTR_W-1:8]);
        FLD_STEP:   rb_d = 8'(sel_step);
        FLD_DATA:   rb_d = rd_blocked ? RD_BLOCKED_VAL : 8'h00;
        default:    rb_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_mem_q <= 1'b0;
      rb_q      <= 8'h00;
    end else if (rd_evt) begin
      src_mem_q <= mem_re;
      rb_q      <= rb_d;
    end
  end

  assign cpu_rdata = src_mem_q ? ram_rd : rb_q;

  AST_BLOCKED_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_wr && !rd_en_q && port_hit && (fld == FLD_DATA)
    |=> cpu_rdata == RD_BLOCKED_VAL); // R5

  AST_SINGLE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_vec)); // R9

  AST_IDLE_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req && $past(!cpu_req) |=> $stable(cpu_rdata)); // R4

endmodule

// File: tb/tb_lmp_window.sv
module tb_lmp_window;

  localparam int unsigned MEM_AW = 10;
  localparam int unsigned DEPTH  = 1 << MEM_AW;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       cpu_req, cpu_wr;
  logic [3:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk; // 125 MHz

  lmp_window #(.MEM_AW(MEM_AW)) dut (
    .clk       (clk),
    .arst_n    (arst_n),
    .cpu_req   (cpu_req),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata)
  );

  // ---------------- model ----------------
  logic [7:0]  m_mem [DEPTH];
  logic [15:0] m_ptr [2];
  logic [7:0]  m_step [2];
  logic        m_rden;

  function automatic logic [7:0] model_op(logic wr, logic [3:0] a, logic [7:0] d);
    logic [7:0] e;
    int p;
    e = 8'h00;
    if (a[3:2] == 2'd0) begin
      if (a[1:0] == 2'd0) begin
        if (wr) m_rden = d[0];
        else    e = {7'b0, m_rden};
      end
    end else if (a[3:2] != 2'd3) begin
      p = int'(a[3:2]) - 1;
      case (a[1:0])
        2'd0: if (wr) m_ptr[p][7:0]  = d; else e = m_ptr[p][7:0];
        2'd1: if (wr) m_ptr[p][15:8] = d; else e = m_ptr[p][15:8];
        2'd2: if (wr) m_step[p]      = d; else e = m_step[p];
        default: begin
          if (wr) begin
            m_mem[m_ptr[p][MEM_AW-1:0]] = d;
            m_ptr[p] = m_ptr[p] + {{8{m_step[p][7]}}, m_step[p]};
          end else if (m_rden) begin
            e = m_mem[m_ptr[p][MEM_AW-1:0]];
            m_ptr[p] = m_ptr[p] + {{8{m_step[p][7]}}, m_step[p]};
          end else begin
            e = 8'hFF;
          end
        end
      endcase
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp_v);
    end
  endtask

  task automatic bus(input logic wr, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    q = cpu_rdata;
  endtask

  task automatic wr_op(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q, e;
    e = model_op(1'b1, a, d);
    bus(1'b1, a, d, q);
  endtask

  task automatic rd_op(input string tag, input logic [3:0] a);
    logic [7:0] q, e;
    e = model_op(1'b0, a, 8'h00);
    bus(1'b0, a, 8'h00, q);
    check(tag, q, e);
  endtask

  // port register addresses (R1)
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] P0_LO = 4'h4, P0_HI = 4'h5, P0_ST = 4'h6, P0_DT = 4'h7;
  localparam logic [3:0] P1_LO = 4'h8, P1_HI = 4'h9, P1_ST = 4'hA, P1_DT = 4'hB;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int unsigned seed;
    cpu_req = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    arst_n = 1'b0;
    m_rden = 1'b0;
    for (int p = 0; p < 2; p++) begin m_ptr[p] = 16'h0000; m_step[p] = 8'h01; end
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset values, R1 readback
    rd_op("R2 ctrl reset", A_CTRL);
    rd_op("R2 p0 ptr lo", P0_LO);
    rd_op("R2 p0 ptr hi", P0_HI);
    rd_op("R2 p0 step", P0_ST);
    rd_op("R2 p1 step", P1_ST);
    rd_op("R1 unused addr", 4'hD);

    // R5 blocked read at reset
    rd_op("R5 blocked data", P0_DT);
    rd_op("R5 ptr unmoved", P0_LO);

    // R3 fill memory sequentially through port 0
    for (int i = 0; i < DEPTH; i++) wr_op(P0_DT, 8'((i * 7 + 3) & 8'hFF));
    rd_op("R3 ptr after fill lo", P0_LO);
    rd_op("R3 ptr after fill hi", P0_HI);

    // R4 / R6 step of 4 on port 1, R9 shared memory
    wr_op(A_CTRL, 8'h01);
    rd_op("R1 ctrl bit0", A_CTRL);
    wr_op(P1_LO, 8'h10);
    wr_op(P1_ST, 8'h04);
    for (int i = 0; i < 3; i++) rd_op("R4 step4 read", P1_DT);
    rd_op("R6 ptr after step4", P1_LO);
    rd_op("R9 p0 untouched", P0_HI);

    // R5 dummy read then write
    wr_op(A_CTRL, 8'h00);
    wr_op(P0_HI, 8'h00);
    wr_op(P0_LO, 8'h20);
    rd_op("R5 dummy read", P0_DT);
    wr_op(P0_DT, 8'hA5);
    wr_op(A_CTRL, 8'h01);
    wr_op(P0_LO, 8'h20);
    rd_op("R5 write landed at pointer", P0_DT);
    wr_op(P0_LO, 8'h1F);
    rd_op("R5 neighbour intact", P0_DT);

    // R6 negative step, R7 wrap and aliasing
    wr_op(P0_LO, 8'h02);
    wr_op(P0_ST, 8'hFF);
    for (int i = 0; i < 3; i++) rd_op("R6 step -1 read", P0_DT);
    rd_op("R7 wrap ptr lo", P0_LO);
    rd_op("R7 wrap ptr hi", P0_HI);
    rd_op("R7 alias top of ram", P0_DT);
    wr_op(P0_ST, 8'h01);
    wr_op(P0_LO, 8'hFF);
    wr_op(P0_HI, 8'hFF);
    wr_op(P0_DT, 8'h5C);
    rd_op("R7 wrap to zero", P0_HI);
    wr_op(P1_HI, 8'h04);
    wr_op(P1_LO, 8'h00);
    wr_op(P1_ST, 8'h01);
    rd_op("R7 alias 0x0400 is 0", P1_DT);

    // R8 high byte write takes effect at once
    wr_op(P0_LO, 8'h30);
    wr_op(P0_HI, 8'h00);
    rd_op("R8 read before hi change", P0_DT);
    wr_op(P0_HI, 8'h01);
    rd_op("R8 read after hi change", P0_DT);

    // random mix
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] a;
      logic       w;
      a = 4'($urandom_range(0, 15));
      w = 1'($urandom_range(0, 1));
      if (w) wr_op(a, 8'($urandom_range(0, 255)));
      else   rd_op("R9 random", a);
    end
    for (int a = 0; a < 16; a++) rd_op("R1 final map", 4'(a));

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule